// File: doc/BRIEF.md
# Frame-Aligned DDR Sample Deserializer

This block turns one lane of double-data-rate ADC serial data into parallel sample words. It runs on the bit clock. In every cycle it receives two data bits that were captured outside the block, one on the rising edge and one on the falling edge, together with two samples of the ADC frame clock taken on the same edges. It keeps a short history of the serial stream and, once per frame period of eight bit-clock cycles, cuts a 16-bit word from that history.

The word boundary is not fixed. The block cuts the frame-clock samples from the same window as the data and compares them with a high-then-low reference. While the reference is not seen, the block moves the window one serial bit at a time. After each move it lets two frames pass before it compares again. After four matching frames in a row it raises an aligned flag. Any later mismatch clears the flag and the search starts again. Downstream logic takes a word on each valid strobe and trusts it once the aligned flag is high.

Top module: `ddr_frame_deser`

## Requirements
- R1: The asynchronous active-low reset clears `word`, `word_vld` and `aligned` to zero at once, without waiting for a clock edge, and restarts the frame count and the search.
- R2: The serial order is the rising-edge bit of a cycle, then the falling-edge bit of the same cycle, then the next cycle. A word holds the 16 serial bits that end at the bits of the strobe cycle, with the earliest bit in bit 15. When the window has been moved back by k bits, the word ends k bits before the newest bit.
- R3: `word_vld` is high for exactly one cycle every 8 cycles. It first goes high after the 8th rising clock edge that follows reset release.
- R4: Between two strobes, `word` holds its value.
- R5: A frame matches when its 16 frame-clock samples, read with the same window and bit order as the data, equal 16'hFF00 (high for the first 8 serial bits, low for the last 8).
- R6: A compared frame that does not match moves the window one serial bit earlier in the stream, wrapping after 16 positions. The next 2 frames are then not compared.
- R7: `aligned` goes high together with the strobe of the 4th consecutive matching compared frame. It stays high while the frames keep matching.
- R8: A compared frame that does not match clears `aligned` with that frame's strobe and restarts the count of consecutive matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dat_rise | input | 1 | Data bit captured on the rising edge |
| dat_fall | input | 1 | Data bit captured on the falling edge |
| frm_rise | input | 1 | Frame-clock sample from the rising edge |
| frm_fall | input | 1 | Frame-clock sample from the falling edge |
| word | output | 16 | Parallel sample word, earliest bit in the MSB |
| word_vld | output | 1 | One-cycle strobe for each new word |
| aligned | output | 1 | The word boundary is locked to the frame clock |

## Verification
The hardest case to reach from the ports is losing lock and finding it again: a shift in frame phase after lock must clear the flag, must step through the window positions with the two-frame pause after each step, and must lock again at a new offset. The bench produces this by changing the phase of the frame clock it generates in the middle of a run, without a reset, for several phase values, and by changing the data pattern between runs. A behavioural model kept as a bit queue follows every slip and pause and is compared on every clock. An asynchronous reset is also applied in the middle of a run.

// File: rtl/ddr_deser_pkg.sv
package ddr_deser_pkg;
  // increment with wrap at lim
  function automatic int wrap_inc(input int v, input int lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

  // increment saturating at lim
  function automatic int sat_inc(input int v, input int lim);
    return (v >= lim) ? lim : v + 1;
  endfunction
endpackage

// File: rtl/ddr_pair_hist.sv
module ddr_pair_hist #(
  parameter int HIST = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            b_rise,
  input  logic            b_fall,
  output logic [HIST-1:0] hist_nxt
);
  logic [HIST-1:0] hist_q;

  // rising-edge bit is older than the falling-edge bit
  assign hist_nxt = {hist_q[HIST-3:0], b_rise, b_fall};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_nxt;
  end
endmodule

// File: rtl/frame_tick_gen.sv
module frame_tick_gen #(
  parameter int FRAME_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CNT_W = (FRAME_CYC > 1) ? $clog2(FRAME_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/frame_align_fsm.sv
module frame_align_fsm
  import ddr_deser_pkg::*;
#(
  parameter int W          = 16,
  parameter int MATCH_NEED = 4,
  parameter int HOLDOFF    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [W-1:0]         frame_win,
  output logic [$clog2(W)-1:0] slip,
  output logic                 aligned,
  output logic                 match_evt,
  output logic                 slip_evt
);
  localparam int SLIP_W = $clog2(W);
  localparam int HOLD_W = $clog2(HOLDOFF + 1);
  localparam int RUN_W  = $clog2(MATCH_NEED + 1);
  localparam logic [W-1:0] REF = {{(W/2){1'b1}}, {(W/2){1'b0}}};

  logic [SLIP_W-1:0] slip_q;
  logic [HOLD_W-1:0] hold_q;
  logic [RUN_W-1:0]  run_q;
  logic              al_q;
  logic              cmp_en;

  assign cmp_en    = tick && (hold_q == '0);
  assign match_evt = cmp_en && (frame_win == REF);
  assign slip_evt  = cmp_en && (frame_win != REF);
  assign slip      = slip_q;
  assign aligned   = al_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slip_q <= '0;
      hold_q <= '0;
      run_q  <= '0;
      al_q   <= 1'b0;
    end else if (tick) begin
      if (hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
      end else if (match_evt) begin
        run_q <= RUN_W'(sat_inc(int'(run_q), MATCH_NEED));
        al_q  <= (int'(run_q) >= MATCH_NEED - 1);
      end else begin
        slip_q <= SLIP_W'(wrap_inc(int'(slip_q), W));
        hold_q <= HOLD_W'(HOLDOFF);
        run_q  <= '0;
        al_q   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/word_out_reg.sv
module word_out_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] data_win,
  output logic [W-1:0] word,
  output logic         word_vld
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= tick;
      if (tick) word <= data_win;
    end
  end
endmodule

// File: rtl/ddr_frame_deser.sv
module ddr_frame_deser #(
  parameter int HALF_W     = 8,
  parameter int MATCH_NEED = 4,
  parameter int HOLDOFF    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dat_rise,
  input  logic                dat_fall,
  input  logic                frm_rise,
  input  logic                frm_fall,
  output logic [2*HALF_W-1:0] word,
  output logic                word_vld,
  output logic                aligned
);
  localparam int W      = 2 * HALF_W;
  localparam int HIST   = 2 * W;
  localparam int SLIP_W = $clog2(W);

  logic [HIST-1:0]   dat_hist;
  logic [HIST-1:0]   frm_hist;
  logic [W-1:0]      data_win;
  logic [W-1:0]      frame_win;
  logic [SLIP_W-1:0] slip;
  logic              frame_tick;
  logic              match_evt;
  logic              slip_evt;

  ddr_pair_hist #(.HIST(HIST)) u_dat_hist (
    .clk(clk), .rst_n(rst_n), .b_rise(dat_rise), .b_fall(dat_fall),
    .hist_nxt(dat_hist));

  ddr_pair_hist #(.HIST(HIST)) u_frm_hist (
    .clk(clk), .rst_n(rst_n), .b_rise(frm_rise), .b_fall(frm_fall),
    .hist_nxt(frm_hist));

  frame_tick_gen #(.FRAME_CYC(HALF_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick));

  // the same offset cuts both data and frame samples
  assign data_win  = dat_hist[slip +: W];
  assign frame_win = frm_hist[slip +: W];

  frame_align_fsm #(.W(W), .MATCH_NEED(MATCH_NEED), .HOLDOFF(HOLDOFF)) u_align (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick), .frame_win(frame_win),
    .slip(slip), .aligned(aligned), .match_evt(match_evt), .slip_evt(slip_evt));

  word_out_reg #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick), .data_win(data_win),
    .word(word), .word_vld(word_vld));
endmodule

// File: rtl/ddr_frame_deser_chk.sv
module ddr_frame_deser_chk #(
  parameter int W         = 16,
  parameter int FRAME_CYC = 8,
  parameter int HOLDOFF   = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] word,
  input logic         word_vld,
  input logic         aligned,
  input logic         frame_tick,
  input logic         slip_evt,
  input logic         match_evt
);
  logic [7:0] since_vld;
  logic [7:0] frames_since_slip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_vld         <= '0;
      frames_since_slip <= 8'hFF;
    end else begin
      since_vld <= word_vld ? 8'd1 : since_vld + 8'd1;
      if (slip_evt)
        frames_since_slip <= '0;
      else if (frame_tick && frames_since_slip != 8'hFF)
        frames_since_slip <= frames_since_slip + 8'd1;
    end
  end

  a_r3_strobe_period: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> (since_vld == 8'(FRAME_CYC)));
  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld);
  a_r4_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |-> $stable(word));
  a_r6_slip_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    slip_evt |-> frame_tick);
  a_r6_pause_after_slip: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_evt || match_evt) |-> (frames_since_slip >= 8'(HOLDOFF)));
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({slip_evt, match_evt}) <= 1);
  a_r7_rise_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned) |-> word_vld);
  a_r8_fall_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aligned) |-> word_vld);
endmodule

bind ddr_frame_deser ddr_frame_deser_chk #(
  .W(2*HALF_W), .FRAME_CYC(HALF_W), .HOLDOFF(HOLDOFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .word(word), .word_vld(word_vld),
  .aligned(aligned), .frame_tick(frame_tick), .slip_evt(slip_evt),
  .match_evt(match_evt));

// File: tb/ddr_frame_deser_bench.sv
module ddr_frame_deser_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dat_rise = 1'b0, dat_fall = 1'b0, frm_rise = 1'b0, frm_fall = 1'b0;
  logic [15:0] word;
  logic word_vld, aligned;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ddr_frame_deser u_ddr_frame_deser (
    .clk(clk), .rst_n(rst_n), .dat_rise(dat_rise), .dat_fall(dat_fall),
    .frm_rise(frm_rise), .frm_fall(frm_fall),
    .word(word), .word_vld(word_vld), .aligned(aligned));

  // reference model state
  bit dq[$];
  bit fq[$];
  logic [15:0] exp_word;
  bit exp_vld, exp_al;
  int m_cyc, m_slip, m_hold, m_run;
  string al_tag;
  int nbit = 0;
  int phi = 0;
  int pat = 0;
  int drops = 0;
  int strobes = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    dq.delete(); fq.delete();
    for (int i = 0; i < 32; i++) begin dq.push_back(0); fq.push_back(0); end
    exp_word = '0; exp_vld = 0; exp_al = 0;
    m_cyc = 0; m_slip = 0; m_hold = 0; m_run = 0; al_tag = "R8";
  endtask

  // the 16 serial bits ending s bits before the newest, earliest first
  function automatic logic [15:0] pick(input bit frm, input int s);
    logic [15:0] w;
    for (int i = 0; i < 16; i++) w[15-i] = frm ? fq[16-s+i] : dq[16-s+i];
    return w;
  endfunction

  task automatic model_edge(input bit r, input bit f, input bit fr, input bit ff);
    logic [15:0] fw;
    dq.push_back(r); dq.push_back(f); void'(dq.pop_front()); void'(dq.pop_front());
    fq.push_back(fr); fq.push_back(ff); void'(fq.pop_front()); void'(fq.pop_front());
    if (m_cyc == 7) begin
      exp_vld = 1;
      exp_word = pick(0, m_slip);
      fw = pick(1, m_slip);
      if (m_hold > 0) m_hold--;
      else if (fw == 16'hFF00) begin
        if (m_run < 4) m_run++;
        exp_al = (m_run == 4);
        al_tag = exp_al ? "R7" : "R5";
      end else begin
        m_slip = (m_slip + 1) % 16;
        m_hold = 2; m_run = 0; exp_al = 0;
        al_tag = "R6";
      end
    end else exp_vld = 0;
    m_cyc = (m_cyc + 1) % 8;
  endtask

  function automatic bit fbit(input int n);
    return ((n + phi) % 16) < 8;
  endfunction

  function automatic bit dbit(input int n);
    case (pat)
      0: return 1'($urandom());
      1: return n[0];
      default: return n[2] ^ n[4] ^ n[0];
    endcase
  endfunction

  // called at a falling edge: drive, step one clock, compare at next falling edge
  task automatic step();
    bit r, f, fr, ff, prev_al;
    r = dbit(nbit); f = dbit(nbit + 1); fr = fbit(nbit); ff = fbit(nbit + 1);
    nbit += 2;
    dat_rise = r; dat_fall = f; frm_rise = fr; frm_fall = ff;
    prev_al = exp_al;
    @(posedge clk);
    model_edge(r, f, fr, ff);
    @(negedge clk);
    if (prev_al && !exp_al) drops++;
    if (word_vld) strobes++;
    check(word_vld == exp_vld, "R3 word_vld", 32'(word_vld), 32'(exp_vld));
    check(word == exp_word, exp_vld ? "R2 word" : "R4 word held", 32'(word), 32'(exp_word));
    check(aligned == exp_al, al_tag, 32'(aligned), 32'(exp_al));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    model_reset();
    check(word == 16'h0, "R1 word", 32'(word), 0);
    check(word_vld == 1'b0, "R1 word_vld", 32'(word_vld), 0);
    check(aligned == 1'b0, "R1 aligned", 32'(aligned), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_phase(input int ph, input int pt, input int cycles);
    int d0, s0;
    phi = ph; pat = pt; d0 = drops; s0 = strobes;
    for (int i = 0; i < cycles; i++) step();
    check(aligned == 1'b1, "R7 locked at end of run", 32'(aligned), 1);
    check(strobes - s0 == cycles / 8, "R3 strobe count", 32'(strobes - s0), 32'(cycles / 8));
  endtask

  initial begin
    model_reset();
    do_reset();
    run_phase(0, 0, 600);
    run_phase(5, 0, 600);
    check(drops >= 1, "R8 lock lost on phase shift", 32'(drops), 1);
    // asynchronous reset in the middle of a run
    for (int i = 0; i < 13; i++) step();
    do_reset();
    run_phase(11, 1, 600);
    run_phase(3, 2, 600);
    run_phase(15, 0, 600);
    check(drops >= 3, "R8 lock lost on each shift", 32'(drops), 3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule